// File: doc/BRIEF.md
# Dual-Buffer Ethernet Receive Buffer Controller

This block is the receive half of a small memory-mapped Ethernet MAC. Received frames arrive as a byte stream with start-of-frame and end-of-frame markers. Each frame is written into one of two receive buffers that are free. When the last byte has been stored, the block sets that buffer's done flag. The block can also raise an interrupt. A host reads the frame over a 32-bit bus and then clears the done flag, which hands the buffer back to the hardware.

The two buffers are filled in turn, and each one is released on its own. Ownership is carried only by the two per-buffer done bits. The stored frame keeps every Ethernet header byte at its natural offset, so the type/length field sits at bytes 12 and 13 of the buffer. If both buffers are still held by the host, an arriving frame is thrown away and a drop counter advances.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, both done flags and both interrupt-enable bits are 0, both status words read 0, `rx_irq` is 0 and `drop_count` is 0.
- R2: Buffer 0 data starts at byte address 0x1000 and buffer 1 data starts at 0x1800. Frame byte n is stored in the 32-bit word at base + 4*(n/4), in bits [8*(n%4)+7 : 8*(n%4)] (little-endian lanes). Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled.
- R3: The first frame after reset goes to buffer 0. Each accepted frame moves the preferred buffer to the opposite of the one just filled, so when both buffers are free, consecutive frames land in opposite buffers.
- R4: The status word of buffer 0 is at 0x17FC and that of buffer 1 is at 0x1FFC. Bit 0 is done and bit 3 is interrupt enable; all other bits read 0. Done is set at the clock edge that takes the end-of-frame byte.
- R5: A host write to a status word with bit 0 = 0 clears that buffer's done flag. A write with bit 0 = 1 leaves done unchanged. Every status write loads bit 3 into the interrupt enable.
- R6: If the preferred buffer still has done set and the other buffer is free, the frame is stored in the other buffer.
- R7: A frame that starts while both done flags are set is discarded. `drop_count` increments by one, and neither buffer's contents nor its status change.
- R8: `rx_irq` is high exactly when `irq_master_en` is high and some buffer has both its done flag and its interrupt enable set.
- R9: Only the first 1518 bytes of a longer frame are stored. The buffer is still marked done at end-of-frame, and nothing is written into the other buffer.
- R10: Bytes that arrive while no frame is open (valid without a start marker) are ignored. This holds even when they carry an end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 13 | Host byte address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, one cycle after `bus_rd` |
| irq_master_en | input | 1 | Global interrupt enable |
| rx_irq | output | 1 | Receive interrupt |
| drop_count | output | DROP_W | Frames discarded because both buffers were full |

## Verification
Done flags and the drop count change at the clock edge that takes the start or end byte. The bench therefore reads them back only after the input burst has been lowered on the following falling edge. Bus reads return data one cycle after the strobe, so each read raises `bus_rd` on a falling edge and samples `bus_rdata` on the next falling edge. `rx_irq` is a combinational function of registered flags, so it is sampled on the falling edge after the status write that changes it. A table of frames walks the buffers through alternation, redirection and dropping, checking both buffers' full contents after every step. Directed tests then cover reset, flag clearing, interrupt gating, truncation and stray bytes.

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf #(
  parameter int FRAME_BYTES = 1518,
  parameter int DROP_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [12:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_master_en,
  output logic              rx_irq,
  output logic [DROP_W-1:0] drop_count
);
  localparam int WORDS  = (FRAME_BYTES + 3) / 4;
  localparam int WIDX_W = $clog2(2 * WORDS);
  localparam int CNT_W  = $clog2(FRAME_BYTES + 1);
  localparam logic [CNT_W-1:0]  LIMIT     = CNT_W'(FRAME_BYTES);
  localparam logic [8:0]        WORDS9    = 9'(WORDS);
  localparam logic [8:0]        STAT_SLOT = 9'h1FF;
  localparam logic [WIDX_W-1:0] HI_BASE   = WIDX_W'(WORDS);

  logic [1:0]       done, ie;
  logic             nxt, tgt, busy;
  logic [CNT_W-1:0] cnt;
  logic             choose, room;

  always_comb begin
    if (!done[nxt]) begin
      choose = nxt;
      room   = 1'b1;
    end else if (!done[~nxt]) begin
      choose = ~nxt;
      room   = 1'b1;
    end else begin
      choose = nxt;
      room   = 1'b0;
    end
  end

  logic             start, take, wr_en, fin, fin_buf, stat_hit;
  logic [CNT_W-1:0] pos;
  logic [1:0]       set_mask, clr_mask;
  logic [WIDX_W-1:0] widx;

  assign start    = rx_valid & rx_sof;
  assign take     = rx_valid & (start ? room : busy);
  assign pos      = start ? '0 : cnt;
  assign wr_en    = take & (pos < LIMIT);
  assign fin      = take & rx_eof;
  assign fin_buf  = start ? choose : tgt;
  assign widx     = (fin_buf ? HI_BASE : '0) + WIDX_W'(pos >> 2);
  assign set_mask = fin ? (fin_buf ? 2'b10 : 2'b01) : 2'b00;
  assign stat_hit = bus_wr & bus_addr[12] & (bus_addr[10:2] == STAT_SLOT);
  assign clr_mask = (stat_hit & ~bus_wdata[0]) ? (bus_addr[11] ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= '0;
      ie         <= '0;
      nxt        <= 1'b0;
      tgt        <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      drop_count <= '0;
    end else begin
      done <= (done & ~clr_mask) | set_mask;
      if (stat_hit) ie[bus_addr[11]] <= bus_wdata[3];
      if (start) begin
        tgt  <= choose;
        busy <= room & ~rx_eof;
        cnt  <= CNT_W'(1);
        if (!room) drop_count <= drop_count + 1'b1;
      end else if (take) begin
        if (cnt < LIMIT) cnt <= cnt + 1'b1;
        if (rx_eof) busy <= 1'b0;
      end
      if (fin) nxt <= ~fin_buf;
    end
  end

  logic              rd_space, rd_is_stat, rd_is_data, rd_is_stat_q, rd_is_data_q;
  logic [8:0]        roff;
  logic [WIDX_W-1:0] ridx;
  logic [31:0]       stat_q, data_word;

  assign rd_space   = bus_addr[12];
  assign rd_is_stat = rd_space & (bus_addr[10:2] == STAT_SLOT);
  assign rd_is_data = rd_space & (bus_addr[10:2] < WORDS9);
  assign roff       = rd_is_data ? bus_addr[10:2] : 9'd0;
  assign ridx       = (bus_addr[11] ? HI_BASE : '0) + WIDX_W'(roff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_is_stat_q <= 1'b0;
      rd_is_data_q <= 1'b0;
      stat_q       <= '0;
    end else if (bus_rd) begin
      rd_is_stat_q <= rd_is_stat;
      rd_is_data_q <= rd_is_data;
      stat_q       <= {28'd0, ie[bus_addr[11]], 2'b00, done[bus_addr[11]]};
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] lane_mem [2*WORDS];
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (wr_en && pos[1:0] == 2'(l)) lane_mem[widx] <= rx_data;
      if (bus_rd) lane_q <= lane_mem[ridx];
    end
    assign data_word[8*l +: 8] = lane_q;
  end

  assign bus_rdata = rd_is_data_q ? data_word : (rd_is_stat_q ? stat_q : 32'd0);
  assign rx_irq    = irq_master_en & |(done & ie);

  logic unused_ok;
  assign unused_ok = ^{bus_wdata[31:4], bus_wdata[2:1], bus_addr[1:0]};
endmodule

// File: rtl/rx_pingpong_buf_chk.sv
module rx_pingpong_buf_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_eof,
  input logic              bus_wr,
  input logic [12:0]       bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [1:0]        done,
  input logic              irq_master_en,
  input logic              rx_irq,
  input logic [DROP_W-1:0] drop_count
);
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> irq_master_en);

  a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (done != 2'b00));

  a_r4_done_rise_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(done)) != 2'b00) |-> $past(rx_valid && rx_eof));

  a_r3_one_fill_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(done & ~$past(done)) <= 1);

  a_r5_clear0_by_host: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done[0]) && !done[0]) |-> $past(bus_wr && bus_addr == 13'h17FC && !bus_wdata[0]));

  a_r5_clear1_by_host: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done[1]) && !done[1]) |-> $past(bus_wr && bus_addr == 13'h1FFC && !bus_wdata[0]));

  a_r7_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> ($past(done) == 2'b11));
endmodule

bind rx_pingpong_buf rx_pingpong_buf_chk #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .done(done), .irq_master_en(irq_master_en), .rx_irq(rx_irq),
  .drop_count(drop_count)
);

// File: tb/rx_pingpong_buf_tb_top.sv
`timescale 1ns/100ps
module rx_pingpong_buf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_master_en = 1'b0;
  logic        rx_irq;
  logic [15:0] drop_count;

  always #2.5 clk = ~clk;

  rx_pingpong_buf dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_master_en(irq_master_en), .rx_irq(rx_irq), .drop_count(drop_count)
  );

  localparam logic [12:0] STAT0 = 13'h17FC;
  localparam logic [12:0] STAT1 = 13'h1FFC;

  // {release mask[1:0], length[11:0], seed[7:0], expected buffer[1:0] (2 = dropped)}
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    {2'b00, 12'd20, 8'h11, 2'd0},
    {2'b00, 12'd7,  8'h52, 2'd1},
    {2'b00, 12'd5,  8'h90, 2'd2},
    {2'b01, 12'd9,  8'hA3, 2'd0},
    {2'b01, 12'd13, 8'h37, 2'd0},
    {2'b11, 12'd64, 8'hC5, 2'd1},
    {2'b00, 12'd1,  8'h6E, 2'd0}
  };

  int checks = 0;
  int errors = 0;
  int last_len [2] = '{0, 0};
  logic [7:0] last_seed [2] = '{8'h00, 8'h00};

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(3 * i);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic send(input int len, input logic [7:0] seed, input bit with_sof);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = with_sof && (i == 0); rx_eof = (i == len - 1);
      rx_data = pat(seed, i);
    end
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic verify_buf(input int b, input string req);
    logic [31:0] w, m, e;
    int bad = 0;
    logic [31:0] fa = '0, fe = '0;
    for (int k = 0; k < (last_len[b] + 3) / 4; k++) begin
      rd(13'h1000 + 13'(b * 13'h800) + 13'(4 * k), w);
      m = '0; e = '0;
      for (int l = 0; l < 4; l++)
        if (4 * k + l < last_len[b]) begin
          m[8*l +: 8] = 8'hFF;
          e[8*l +: 8] = pat(last_seed[b], 4 * k + l);
        end
      if ((w & m) != e) begin
        if (bad == 0) begin fa = w & m; fe = e; end
        bad++;
      end
    end
    chk(bad == 0, req, fa, fe);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int exp_drop = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(STAT0, d); chk(d == 0, "R1 status0", d, 0);
    rd(STAT1, d); chk(d == 0, "R1 status1", d, 0);
    chk(rx_irq == 0, "R1 irq", 32'(rx_irq), 0);
    chk(drop_count == 0, "R1 drop", 32'(drop_count), 0);

    // R2 R3 R6 R7 table walk
    for (int v = 0; v < NV; v++) begin
      logic [1:0] clr, eb;
      int len;
      logic [7:0] seed;
      clr = VEC[v][23:22]; len = int'(VEC[v][21:10]); seed = VEC[v][9:2]; eb = VEC[v][1:0];
      if (clr[0]) wr(STAT0, 32'd0);
      if (clr[1]) wr(STAT1, 32'd0);
      send(len, seed, 1'b1);
      if (eb == 2'd2) begin
        exp_drop++;
        chk(drop_count == 16'(exp_drop), "R7 drop count", 32'(drop_count), 32'(exp_drop));
        rd(STAT0, d); chk(d == 1, "R7 status0 kept", d, 1);
        rd(STAT1, d); chk(d == 1, "R7 status1 kept", d, 1);
        verify_buf(0, "R7 buf0 untouched");
        verify_buf(1, "R7 buf1 untouched");
      end else begin
        last_len[eb] = len; last_seed[eb] = seed;
        rd(eb[0] ? STAT1 : STAT0, d);
        chk(d == 1, "R4 done after frame", d, 1);
        verify_buf(int'(eb), "R2 R3 R6 frame contents");
        chk(drop_count == 16'(exp_drop), "R7 no spurious drop", 32'(drop_count), 32'(exp_drop));
      end
    end

    // R5 / R8: both done now; preferred next buffer is 1
    wr(STAT0, 32'h9);
    rd(STAT0, d); chk(d == 32'h9, "R5 write one keeps done", d, 32'h9);
    chk(rx_irq == 0, "R8 irq masked by master", 32'(rx_irq), 0);
    @(negedge clk) irq_master_en = 1'b1;
    @(negedge clk) chk(rx_irq == 1, "R8 irq asserted", 32'(rx_irq), 1);
    wr(STAT0, 32'h8);
    chk(rx_irq == 0, "R8 irq drops with done", 32'(rx_irq), 0);
    rd(STAT0, d); chk(d == 32'h8, "R5 write zero clears done", d, 32'h8);

    // R9 truncation into buffer 1
    wr(STAT1, 32'd0);
    send(1530, 8'h40, 1'b1);
    rd(STAT1, d); chk(d == 1, "R9 done after long frame", d, 1);
    rd(13'h1800, d);
    chk(d == {pat(8'h40,3), pat(8'h40,2), pat(8'h40,1), pat(8'h40,0)}, "R9 first word", d,
        {pat(8'h40,3), pat(8'h40,2), pat(8'h40,1), pat(8'h40,0)});
    rd(13'h1800 + 13'(4 * 379), d);
    chk(d[15:0] == {pat(8'h40,1517), pat(8'h40,1516)}, "R9 last stored bytes", 32'(d[15:0]),
        32'({pat(8'h40,1517), pat(8'h40,1516)}));
    rd(13'h1000, d);
    chk(d[7:0] == pat(8'h6E, 0), "R9 other buffer intact", 32'(d[7:0]), 32'(pat(8'h6E, 0)));

    // R10 stray bytes with no open frame
    wr(STAT0, 32'h8);
    wr(STAT1, 32'd0);
    send(10, 8'hF0, 1'b0);
    rd(STAT0, d); chk(d == 32'h8, "R10 status0 unchanged", d, 32'h8);
    rd(STAT1, d); chk(d == 0, "R10 status1 unchanged", d, 0);
    rd(13'h1000, d);
    chk(d[7:0] == pat(8'h6E, 0), "R10 buf0 data unchanged", 32'(d[7:0]), 32'(pat(8'h6E, 0)));
    chk(drop_count == 16'(exp_drop), "R10 drop unchanged", 32'(drop_count), 32'(exp_drop));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule